// File: doc/BRIEF.md
# ADC Calibration and Conversion Sequencer

This block is the control state machine that decides what a converter's analog core does next. It watches a convert-start strobe and control-register writes. It runs a two-step power-on routine: first a settling timeout, then an automatic full self-calibration. After that, each strobe starts a normal conversion. A register write can also launch a calibration of a chosen type. BUSY stays high while any timed activity runs, and strobes or requests that arrive during that time are dropped.

The analog core is driven by one-cycle start pulses, which rise in the first BUSY cycle of each activity. A calibration kind output and a sub-phase output tell the trim logic which correction step is active. Every duration is a parameter counted in master-clock cycles, so a bench can shorten each one to a few cycles.

An early register write cancels the pending automatic calibration. It never shortens the settling timeout or a calibration that has already started.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, BUSY is low, both start pulses are low, the sub-phase is 00 and the stored kind is 00. BUSY stays low until a convert strobe arrives.
- R2: The first convert strobe after reset starts no conversion. BUSY goes high in the next cycle and stays high for exactly SETTLE_CYC cycles.
- R3: A convert strobe that arrives while BUSY is high is ignored. It does not lengthen the busy time and produces no start pulse.
- R4: The first strobe after the timeout, with no cancelling write, starts the automatic calibration. The calibration start pulse and kind 00 (full) appear in the first busy cycle, and BUSY lasts AUTO_CAL_CYC cycles.
- R5: Once the power-on routine is over, each accepted strobe pulses the conversion start in the first busy cycle and holds BUSY for CONV_CYC cycles. The conversion-done output is high only in the last of those cycles.
- R6: A register write made after reset and before the automatic calibration starts cancels that calibration. Such a write does not shorten the settling timeout, and the next strobe starts a conversion.
- R7: A register write made during any calibration does not abort it, and BUSY keeps its full length.
- R8: A register write with the go bit set, made while BUSY is low after the timeout, starts the calibration selected by the 2-bit type field. The encodings and durations are: 00 full (FULL_CAL_CYC), 01 gain then offset (GAIN_OFS_CYC), 10 offset (OFS_CAL_CYC), 11 gain (GAIN_CAL_CYC). The kind output shows the type from the first busy cycle onward.
- R9: The sub-phase output reads 00 when no calibration runs, 11 during a full calibration, 10 during offset, and 01 during gain. During a gain-then-offset calibration it reads 01 for the first floor(GAIN_OFS_CYC/2) cycles and 10 for the rest.
- R10: A calibration request made while BUSY is high, or before the settling timeout has completed, is ignored.
- R11: If a strobe and a write arrive in the same idle cycle, a write with go set wins and the strobe is dropped. A write without go cancels any pending automatic calibration, and the strobe then starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start_i | input | 1 | Convert-start strobe, one cycle |
| reg_wr_i | input | 1 | Control-register write strobe |
| cal_go_i | input | 1 | Calibration go bit of the write |
| cal_sel_i | input | 2 | Calibration type of the write |
| busy_o | output | 1 | High while a timeout, calibration or conversion runs |
| conv_kick_o | output | 1 | Conversion start pulse to the analog core |
| cal_kick_o | output | 1 | Calibration start pulse to the analog core |
| cal_kind_o | output | 2 | Type of the latest calibration |
| cal_phase_o | output | 2 | Active correction step: 00 none, 01 gain, 10 offset, 11 all |
| conv_done_o | output | 1 | High in the last busy cycle of a conversion |

## Verification
A wrong state or a lost auto-pending flag shows up at the ports one cycle after the strobe that exposes it. The wrong start pulse rises, or BUSY has the wrong length. A miscounted timer shows as a BUSY fall that is one or more cycles early or late. A wrong phase split inside a gain-then-offset calibration shows as a changed count of 01 cycles. The reference model compares every output on every clock, so any such fault is reported in the cycle it first appears.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [2:0] {
    S_FRESH  = 3'd0,
    S_SETTLE = 3'd1,
    S_IDLE   = 3'd2,
    S_CONV   = 3'd3,
    S_CAL    = 3'd4
  } seq_state_e;

  localparam logic [1:0] KIND_FULL     = 2'b00;
  localparam logic [1:0] KIND_GAIN_OFS = 2'b01;
  localparam logic [1:0] KIND_OFS      = 2'b10;
  localparam logic [1:0] KIND_GAIN     = 2'b11;

  localparam logic [1:0] PH_NONE = 2'b00;
  localparam logic [1:0] PH_GAIN = 2'b01;
  localparam logic [1:0] PH_OFS  = 2'b10;
  localparam logic [1:0] PH_ALL  = 2'b11;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Counter value at or above which a split calibration is still in its gain step
  function automatic int unsigned gain_floor(input int unsigned total);
    return total - total / 2;
  endfunction

endpackage

// File: rtl/cal_seq_timer.sv
module cal_seq_timer #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // R2: the count only ever steps down by one between loads
  a_r2_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cal_seq_phase.sv
module cal_seq_phase
  import cal_seq_pkg::*;
#(
  parameter int unsigned CNT_W        = 17,
  parameter int unsigned GAIN_OFS_CYC = 27760
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_cal_i,
  input  logic [1:0]       kind_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [1:0]       phase_o
);
  localparam logic [CNT_W-1:0] GAIN_FLOOR = CNT_W'(gain_floor(GAIN_OFS_CYC));

  logic gain_step;
  assign gain_step = (cnt_i >= GAIN_FLOOR);

  always_comb begin
    phase_o = PH_NONE;
    if (in_cal_i) begin
      case (kind_i)
        KIND_FULL:     phase_o = PH_ALL;
        KIND_GAIN_OFS: phase_o = gain_step ? PH_GAIN : PH_OFS;
        KIND_OFS:      phase_o = PH_OFS;
        default:       phase_o = PH_GAIN;
      endcase
    end
  end

  // R9: in a split calibration the gain step never returns after the offset step began
  a_r9_gain_before_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cal_i && kind_i == KIND_GAIN_OFS && phase_o == PH_OFS) |=> (phase_o != PH_GAIN));
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_seq_pkg::*;
#(
  parameter int unsigned CNT_W        = 17,
  parameter int unsigned SETTLE_CYC   = 128000,
  parameter int unsigned AUTO_CAL_CYC = 128000,
  parameter int unsigned FULL_CAL_CYC = 125000,
  parameter int unsigned GAIN_OFS_CYC = 27760,
  parameter int unsigned OFS_CAL_CYC  = 13880,
  parameter int unsigned GAIN_CAL_CYC = 13880,
  parameter int unsigned CONV_CYC     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_start_i,
  input  logic             reg_wr_i,
  input  logic             cal_go_i,
  input  logic [1:0]       cal_sel_i,
  input  logic             tmr_zero_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             busy_o,
  output logic             in_cal_o,
  output logic [1:0]       kind_o,
  output logic             conv_kick_o,
  output logic             cal_kick_o,
  output logic             conv_done_o
);
  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] AUTO_LD   = CNT_W'(AUTO_CAL_CYC - 1);
  localparam logic [CNT_W-1:0] FULL_LD   = CNT_W'(FULL_CAL_CYC - 1);
  localparam logic [CNT_W-1:0] GO_LD     = CNT_W'(GAIN_OFS_CYC - 1);
  localparam logic [CNT_W-1:0] OFS_LD    = CNT_W'(OFS_CAL_CYC - 1);
  localparam logic [CNT_W-1:0] GAIN_LD   = CNT_W'(GAIN_CAL_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LD   = CNT_W'(CONV_CYC - 1);

  function automatic logic [CNT_W-1:0] cal_load(input logic [1:0] sel);
    case (sel)
      KIND_FULL:     return FULL_LD;
      KIND_GAIN_OFS: return GO_LD;
      KIND_OFS:      return OFS_LD;
      default:       return GAIN_LD;
    endcase
  endfunction

  seq_state_e state_q, state_n;
  logic       auto_pend_q, auto_pend_n;
  logic [1:0] kind_q, kind_n;
  logic       start_conv, start_cal;
  logic       conv_kick_q, cal_kick_q;

  always_comb begin
    state_n     = state_q;
    auto_pend_n = auto_pend_q;
    kind_n      = kind_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    start_conv  = 1'b0;
    start_cal   = 1'b0;
    case (state_q)
      S_FRESH: begin
        if (reg_wr_i) auto_pend_n = 1'b0;
        if (conv_start_i) begin
          state_n    = S_SETTLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = SETTLE_LD;
        end
      end
      S_SETTLE: begin
        if (reg_wr_i) auto_pend_n = 1'b0;
        if (tmr_zero_i) state_n = S_IDLE;
      end
      S_IDLE: begin
        if (reg_wr_i) auto_pend_n = 1'b0;
        if (reg_wr_i && cal_go_i) begin
          start_cal = 1'b1;
          kind_n    = cal_sel_i;
          tmr_val_o = cal_load(cal_sel_i);
        end else if (conv_start_i && auto_pend_q && !reg_wr_i) begin
          start_cal   = 1'b1;
          auto_pend_n = 1'b0;
          kind_n      = KIND_FULL;
          tmr_val_o   = AUTO_LD;
        end else if (conv_start_i) begin
          start_conv = 1'b1;
          tmr_val_o  = CONV_LD;
        end
        tmr_load_o = start_cal | start_conv;
        if (start_cal)  state_n = S_CAL;
        if (start_conv) state_n = S_CONV;
      end
      default: begin
        if (tmr_zero_i) state_n = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_FRESH;
      auto_pend_q <= 1'b1;
      kind_q      <= KIND_FULL;
      conv_kick_q <= 1'b0;
      cal_kick_q  <= 1'b0;
    end else begin
      state_q     <= state_n;
      auto_pend_q <= auto_pend_n;
      kind_q      <= kind_n;
      conv_kick_q <= start_conv;
      cal_kick_q  <= start_cal;
    end
  end

  assign busy_o      = (state_q == S_SETTLE) || (state_q == S_CONV) || (state_q == S_CAL);
  assign in_cal_o    = (state_q == S_CAL);
  assign kind_o      = kind_q;
  assign conv_kick_o = conv_kick_q;
  assign cal_kick_o  = cal_kick_q;
  assign conv_done_o = (state_q == S_CONV) && tmr_zero_i;

  // R3: a busy cycle is never followed by a fresh start pulse
  a_r3_busy_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (!conv_kick_o && !cal_kick_o));
  // R1: the two start pulses never coincide
  a_r1_kicks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_kick_o, cal_kick_o}));
  // R2: the settling timeout emits no start pulse
  a_r2_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SETTLE) |-> (!conv_kick_o && !cal_kick_o));
  // R6: a write never cuts the settling timeout short
  a_r6_settle_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SETTLE && !tmr_zero_i) |=> (state_q == S_SETTLE));
  // R7: a running calibration is held until its count expires
  a_r7_cal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CAL && !tmr_zero_i) |=> (state_q == S_CAL));
  // R5: conversion-done is followed by BUSY low
  a_r5_done_then_free: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done_o |=> !busy_o);
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
  import cal_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC   = 128000,
  parameter int unsigned AUTO_CAL_CYC = 128000,
  parameter int unsigned FULL_CAL_CYC = 125000,
  parameter int unsigned GAIN_OFS_CYC = 27760,
  parameter int unsigned OFS_CAL_CYC  = 13880,
  parameter int unsigned GAIN_CAL_CYC = 13880,
  parameter int unsigned CONV_CYC     = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_start_i,
  input  logic       reg_wr_i,
  input  logic       cal_go_i,
  input  logic [1:0] cal_sel_i,
  output logic       busy_o,
  output logic       conv_kick_o,
  output logic       cal_kick_o,
  output logic [1:0] cal_kind_o,
  output logic [1:0] cal_phase_o,
  output logic       conv_done_o
);
  localparam int unsigned MAX_CYC = max2(max2(max2(SETTLE_CYC, AUTO_CAL_CYC),
                                              max2(FULL_CAL_CYC, GAIN_OFS_CYC)),
                                         max2(max2(OFS_CAL_CYC, GAIN_CAL_CYC), CONV_CYC));
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_zero, in_cal;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;

  cal_seq_ctrl #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC), .AUTO_CAL_CYC(AUTO_CAL_CYC),
    .FULL_CAL_CYC(FULL_CAL_CYC), .GAIN_OFS_CYC(GAIN_OFS_CYC),
    .OFS_CAL_CYC(OFS_CAL_CYC), .GAIN_CAL_CYC(GAIN_CAL_CYC), .CONV_CYC(CONV_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_start_i(conv_start_i), .reg_wr_i(reg_wr_i),
    .cal_go_i(cal_go_i), .cal_sel_i(cal_sel_i), .tmr_zero_i(tmr_zero),
    .tmr_load_o(tmr_load), .tmr_val_o(tmr_val), .busy_o(busy_o), .in_cal_o(in_cal),
    .kind_o(cal_kind_o), .conv_kick_o(conv_kick_o), .cal_kick_o(cal_kick_o),
    .conv_done_o(conv_done_o)
  );

  cal_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .load_val_i(tmr_val),
    .cnt_o(tmr_cnt), .zero_o(tmr_zero)
  );

  cal_seq_phase #(.CNT_W(CNT_W), .GAIN_OFS_CYC(GAIN_OFS_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .in_cal_i(in_cal), .kind_i(cal_kind_o),
    .cnt_i(tmr_cnt), .phase_o(cal_phase_o)
  );

  // R9: no correction step is shown while the block is free
  a_r9_free_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cal_phase_o == PH_NONE));
endmodule

// File: tb/tb_cal_sequencer.sv
module tb_cal_sequencer;
  localparam int SETTLE = 20, AUTO = 24, FULL = 16, GO = 12, OFS = 6, GAIN = 7, CONV = 5;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, wr = 1'b0, go = 1'b0;
  logic [1:0] sel = 2'b00;
  logic busy_o, conv_kick_o, cal_kick_o, conv_done_o;
  logic [1:0] cal_kind_o, cal_phase_o;

  cal_sequencer #(
    .SETTLE_CYC(SETTLE), .AUTO_CAL_CYC(AUTO), .FULL_CAL_CYC(FULL), .GAIN_OFS_CYC(GO),
    .OFS_CAL_CYC(OFS), .GAIN_CAL_CYC(GAIN), .CONV_CYC(CONV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .conv_start_i(cs), .reg_wr_i(wr), .cal_go_i(go),
    .cal_sel_i(sel), .busy_o(busy_o), .conv_kick_o(conv_kick_o), .cal_kick_o(cal_kick_o),
    .cal_kind_o(cal_kind_o), .cal_phase_o(cal_phase_o), .conv_done_o(conv_done_o)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model: 0 fresh, 1 settle, 2 idle, 3 conv, 4 cal
  int m_st = 0, m_rem = 0, m_kind = 0, m_pend = 1, m_ck = 0, m_kk = 0, m_dur = 0;
  bit armed = 0;

  function automatic int dur_of(input int s);
    case (s)
      0: return FULL;
      1: return GO;
      2: return OFS;
      default: return GAIN;
    endcase
  endfunction

  always @(posedge clk) begin
    m_ck = 0;
    m_kk = 0;
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_kind = 0; m_pend = 1; m_dur = 0;
    end else begin
      case (m_st)
        0: begin
          if (wr) m_pend = 0;
          if (cs) begin m_st = 1; m_rem = SETTLE; end
        end
        1: begin
          if (wr) m_pend = 0;
          if (m_rem == 1) m_st = 2; else m_rem--;
        end
        2: begin
          if (wr && go) begin
            m_st = 4; m_kind = sel; m_dur = dur_of(sel); m_rem = m_dur; m_ck = 1;
          end else if (cs && m_pend == 1 && !wr) begin
            m_st = 4; m_kind = 0; m_dur = AUTO; m_rem = AUTO; m_ck = 1; m_pend = 0;
          end else if (cs) begin
            m_st = 3; m_rem = CONV; m_kk = 1;
          end
          if (wr) m_pend = 0;
        end
        default: begin
          if (m_rem == 1) m_st = 2; else m_rem--;
        end
      endcase
    end
    armed = 1;
  end

  function automatic int exp_phase();
    if (m_st != 4) return 0;
    case (m_kind)
      0: return 3;
      1: return ((m_dur - m_rem) < m_dur / 2) ? 1 : 2;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  always @(negedge clk) begin
    if (armed && !finished) begin
      chk("R2", busy_o, (m_st == 1 || m_st == 3 || m_st == 4), "busy vs model");
      chk("R5", conv_kick_o, m_kk, "conv start pulse vs model");
      chk("R5", conv_done_o, (m_st == 3 && m_rem == 1), "conv done vs model");
      chk("R8", cal_kick_o, m_ck, "cal start pulse vs model");
      chk("R8", cal_kind_o, m_kind, "kind vs model");
      chk("R9", cal_phase_o, exp_phase(), "phase vs model");
    end
  end

  task automatic pulse(input bit c, input bit w, input bit g, input logic [1:0] s);
    cs = c; wr = w; go = g; sel = s;
    @(posedge clk); #1;
    cs = 0; wr = 0; go = 0;
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  // Counts busy cycles from now, gain-phase cycles, and done in the last busy cycle
  task automatic measure(output int n, output int g, output int d);
    n = 0; g = 0; d = 0;
    while (busy_o) begin
      n++;
      if (cal_phase_o == 2'b01) g++;
      d = conv_done_o;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, g, d;
    do_reset();
    // R1 reset state and no activity without a strobe
    chk("R1", busy_o, 0, "busy after reset");
    chk("R1", cal_phase_o, 0, "phase after reset");
    chk("R1", cal_kind_o, 0, "kind after reset");
    idle(5);
    chk("R1", busy_o, 0, "busy stays low without strobe");

    // R2 first strobe is a settling timeout; R3 strobes ignored meanwhile
    pulse(1, 0, 0, 0);
    chk("R2", busy_o, 1, "busy after first strobe");
    chk("R2", conv_kick_o, 0, "no conversion on first strobe");
    pulse(1, 0, 0, 0);
    pulse(1, 0, 0, 0);
    measure(n, g, d);
    chk("R3", n, SETTLE - 2, "settle length with ignored strobes");

    // R4 automatic calibration; R7 write does not abort; R10 request ignored
    idle(2);
    pulse(1, 0, 0, 0);
    chk("R4", cal_kick_o, 1, "auto calibration start pulse");
    chk("R4", cal_kind_o, 0, "auto calibration kind");
    chk("R4", cal_phase_o, 3, "auto calibration phase");
    pulse(0, 1, 1, 2);
    measure(n, g, d);
    chk("R7", n, AUTO - 1, "auto calibration length after write");
    chk("R10", cal_kind_o, 0, "request during calibration ignored");

    // R5 conversions; R10 request during conversion ignored
    idle(2);
    pulse(1, 0, 0, 0);
    chk("R5", conv_kick_o, 1, "conversion start pulse");
    measure(n, g, d);
    chk("R5", n, CONV, "conversion length");
    chk("R5", d, 1, "done in last busy cycle");
    idle(1);
    pulse(1, 0, 0, 0);
    pulse(0, 1, 1, 3);
    measure(n, g, d);
    chk("R10", n, CONV - 1, "conversion length after ignored request");
    idle(1);
    chk("R10", busy_o, 0, "no calibration after ignored request");

    // R8 each calibration type; R9 gain-then-offset split
    for (int s = 0; s < 4; s++) begin
      idle(1);
      pulse(0, 1, 1, s[1:0]);
      chk("R8", cal_kick_o, 1, "requested calibration start");
      chk("R8", cal_kind_o, s, "requested kind");
      measure(n, g, d);
      chk("R8", n, dur_of(s), "requested calibration length");
      if (s == 1) chk("R9", g, GO / 2, "gain step cycles in split calibration");
      if (s == 3) chk("R9", g, GAIN, "gain-only phase cycles");
    end

    // R11 same-cycle strobe and write
    idle(1);
    pulse(1, 1, 1, 3);
    chk("R11", cal_kick_o, 1, "write with go wins");
    chk("R11", conv_kick_o, 0, "strobe dropped");
    measure(n, g, d);
    chk("R11", n, GAIN, "gain calibration length");
    idle(1);
    pulse(1, 1, 0, 0);
    chk("R11", conv_kick_o, 1, "write without go lets strobe convert");
    measure(n, g, d);

    // R6 write during settle cancels auto calibration; R10 request there ignored
    do_reset();
    pulse(1, 0, 0, 0);
    pulse(0, 1, 0, 0);
    pulse(0, 1, 1, 2);
    measure(n, g, d);
    chk("R6", n, SETTLE - 2, "settle not shortened by write");
    idle(1);
    chk("R10", busy_o, 0, "request during settle ignored");
    pulse(1, 0, 0, 0);
    chk("R6", conv_kick_o, 1, "conversion instead of auto calibration");
    chk("R6", cal_kick_o, 0, "no auto calibration");
    measure(n, g, d);
    chk("R6", n, CONV, "conversion length after cancel");

    // R6 write before the first strobe
    do_reset();
    pulse(0, 1, 0, 0);
    idle(2);
    chk("R6", busy_o, 0, "write alone does not start activity");
    pulse(1, 0, 0, 0);
    measure(n, g, d);
    chk("R6", n, SETTLE, "timeout still runs after early write");
    idle(1);
    pulse(1, 0, 0, 0);
    chk("R6", conv_kick_o, 1, "conversion after early write");
    measure(n, g, d);
    idle(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule